// File: doc/BRIEF.md
# Low-Power Mode Controller

This controller decides which power state a small microcontroller is in and drives the control lines that follow from that state. The states are normal run, sleep, software standby with an oscillator settling phase, hardware standby, and two reset states. Each state has its own way in and its own set of wake-up events. From the current state, the block derives the CPU halt, the master clock enable, the halt and reset lines of every peripheral, the port hold and high-impedance controls, the clock-output pin controls, and the RAM and memory-refresh controls.

A per-module standby register is an input to the block. In run and sleep, each set bit halts its peripheral and holds it in reset, so the peripheral's registers are lost and must be programmed again after the bit is cleared. In software standby and hardware standby, every peripheral is halted and held in reset whatever the register holds. When software standby ends on an interrupt, the CPU clock stays off for a programmable number of cycles while the oscillator settles. After that the interrupt is passed on to the CPU.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high and `stby_n` is high, `mode` is 5 (reset). `cpu_halt` is 1, `clk_en` is 1, and every bit of `mod_halt` and `mod_rst` is 1. One cycle after `rst` falls, `mode` is 0 (run).
- R2: In run, `sleep_req` with `ssby_sel`=0 gives `mode` 1 (sleep) on the next cycle. Sleep has `cpu_halt`=1 and `clk_en`=1.
- R3: In sleep, any of `nmi`, a bit of `irq`, or `irq_pend` returns the block to run on the next cycle. `wake_irq` is 1 for exactly the first run cycle.
- R4: In run, `sleep_req` with `ssby_sel`=1 gives `mode` 2 (software standby). In this state `clk_en`=0, `cpu_halt`=1, `io_hold`=1, `ram_hold`=1, `refresh_halt`=1, and all `mod_halt` and `mod_rst` bits are 1. `refresh_clr` is 1 only in the first software-standby cycle.
- R5: In software standby, only `nmi` or a bit of `irq` ends the state. `irq_pend` and `sleep_req` leave `mode` at 2.
- R6: A wake from software standby gives `mode` 3 (settling) for max(`settle_cycles`,1) cycles, with `clk_en`=0 and `io_hold`=1. Interrupts during this time have no effect. The block then enters run with `wake_irq` high for one cycle.
- R7: `stby_n` low gives `mode` 4 (hardware standby) on the next cycle from any state, even when `rst` is high. In this state `io_hiz`=1, `io_hold`=0, `clk_en`=0, `cpu_regs_lost`=1, `refresh_rst`=1, and all module lines are 1.
- R8: Hardware standby ignores `nmi`, `irq` and `rst`. Once `stby_n` is high it leaves through `mode` 6 (standby recovery reset) for one cycle, or longer while `rst` is held, and then enters run.
- R9: When `rst` and an interrupt arrive in the same sleep cycle, reset wins. The block passes through `mode` 5 and `wake_irq` stays 0 on the following run cycle.
- R10: In run and sleep, `mod_halt` and `mod_rst` each equal `mstb` bit for bit.
- R11: With `clkout_en`=1, `clkout_high` is 1 in modes 2 and 3, and `clkout_hiz` is 1 in mode 4. Both are 0 in every other mode, and both are 0 at all times when `clkout_en`=0.
- R12: `ram_valid` takes the inverse of `ram_en` at the edge that enters hardware standby. It is cleared by `rst` in modes 0 to 3 and 5. It keeps its value in every other case, including modes 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high chip reset |
| stby_n | input | 1 | Hardware standby pin, active low |
| sleep_req | input | 1 | Sleep instruction strobe from the CPU |
| ssby_sel | input | 1 | Selects software standby instead of sleep |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | NIRQ | External interrupt lines |
| irq_pend | input | 1 | Any other interrupt pending |
| mstb | input | NMOD | Per-module standby register |
| ram_en | input | 1 | On-chip RAM enable bit |
| clkout_en | input | 1 | Clock-output pin in use |
| settle_cycles | input | CW | Oscillator settling time in cycles |
| mode | output | 3 | Current state code |
| cpu_halt | output | 1 | Halts the CPU |
| clk_en | output | 1 | Master CPU/peripheral clock enable |
| mod_halt | output | NMOD | Per-module halt |
| mod_rst | output | NMOD | Per-module reset |
| io_hold | output | 1 | Hold port states |
| io_hiz | output | 1 | Put ports in high impedance |
| clkout_high | output | 1 | Drive the clock-output pin high |
| clkout_hiz | output | 1 | Put the clock-output pin in high impedance |
| ram_hold | output | 1 | Place RAM in retention |
| ram_valid | output | 1 | RAM contents survived hardware standby |
| refresh_halt | output | 1 | Halt the memory-refresh interface |
| refresh_clr | output | 1 | Clear the refresh counter and the top two control bits |
| refresh_rst | output | 1 | Fully reset the memory-refresh interface |
| cpu_regs_lost | output | 1 | CPU register contents are undefined |
| wake_irq | output | 1 | Passes the waking interrupt to the CPU |

## Verification
The hardest case to reach is the priority between events that arrive in the same cycle. Examples are the standby pin falling while reset is high, and reset together with an interrupt during sleep. The directed tasks first place the block in the required state through its ports and then drive the competing inputs in the same cycle. The settling window is measured cycle by cycle for both a non-zero and a zero setting. `ram_valid` is followed across a whole hardware-standby round trip: entry, recovery reset, then a later plain reset.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        M_RUN    = 3'd0,
        M_SLEEP  = 3'd1,
        M_SSTBY  = 3'd2,
        M_SETTLE = 3'd3,
        M_HSTBY  = 3'd4,
        M_RESET  = 3'd5,
        M_HSREC  = 3'd6
    } lpm_state_e;

    typedef struct packed {
        logic cpu_halt;
        logic clk_en;
        logic io_hold;
        logic io_hiz;
        logic clkout_high;
        logic clkout_hiz;
        logic ram_hold;
        logic refresh_halt;
        logic refresh_rst;
        logic regs_lost;
    } lpm_ctl_t;

    function automatic logic in_soft_standby(lpm_state_e s);
        return (s == M_SSTBY) || (s == M_SETTLE);
    endfunction

    function automatic logic in_any_reset(lpm_state_e s);
        return (s == M_RESET) || (s == M_HSREC);
    endfunction

endpackage

// File: rtl/lpm_wake.sv
module lpm_wake #(
    parameter int NIRQ = 3
) (
    input  logic            nmi,
    input  logic [NIRQ-1:0] irq,
    input  logic            irq_pend,
    output logic            wake_any,
    output logic            wake_soft
);
    // Software standby only accepts the non-maskable and external lines.
    assign wake_soft = nmi | (|irq);
    assign wake_any  = wake_soft | irq_pend;
endmodule

// File: rtl/lpm_settle.sv
module lpm_settle #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] cycles,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW:0]   elapsed;

    assign elapsed = {1'b0, cnt} + 1'b1;
    assign done    = active && (elapsed >= {1'b0, cycles});

    always_ff @(posedge clk) begin
        if (rst || !active) cnt <= '0;
        else if (!done)     cnt <= cnt + 1'b1;
    end

    // R6
    settle_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (active && cycles != '0) |-> (cnt < cycles));
endmodule

// File: rtl/lpm_outmap.sv
module lpm_outmap
    import lpm_pkg::*;
#(
    parameter int NMOD = 8
) (
    input  lpm_state_e      state,
    input  logic [NMOD-1:0] mstb,
    input  logic            clkout_en,
    output lpm_ctl_t        ctl,
    output logic [NMOD-1:0] mod_halt,
    output logic [NMOD-1:0] mod_rst
);
    logic force_all;

    always_comb begin
        ctl       = '0;
        force_all = 1'b0;
        case (state)
            M_RUN: ;
            M_SLEEP: ctl.cpu_halt = 1'b1;
            M_SSTBY, M_SETTLE: begin
                ctl.cpu_halt     = 1'b1;
                ctl.io_hold      = 1'b1;
                ctl.clkout_high  = clkout_en;
                ctl.ram_hold     = 1'b1;
                ctl.refresh_halt = 1'b1;
                force_all        = 1'b1;
            end
            M_HSTBY: begin
                ctl.cpu_halt     = 1'b1;
                ctl.io_hiz       = 1'b1;
                ctl.clkout_hiz   = clkout_en;
                ctl.ram_hold     = 1'b1;
                ctl.refresh_halt = 1'b1;
                ctl.refresh_rst  = 1'b1;
                ctl.regs_lost    = 1'b1;
                force_all        = 1'b1;
            end
            default: begin
                ctl.cpu_halt    = 1'b1;
                ctl.refresh_rst = 1'b1;
                force_all       = 1'b1;
            end
        endcase
        ctl.clk_en = !(in_soft_standby(state) || state == M_HSTBY);
    end

    for (genvar i = 0; i < NMOD; i++) begin : g_mod
        assign mod_halt[i] = force_all | mstb[i];
        assign mod_rst[i]  = force_all | mstb[i];
    end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int NMOD = 8,
    parameter int NIRQ = 3,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stby_n,
    input  logic            sleep_req,
    input  logic            ssby_sel,
    input  logic            nmi,
    input  logic [NIRQ-1:0] irq,
    input  logic            irq_pend,
    input  logic [NMOD-1:0] mstb,
    input  logic            ram_en,
    input  logic            clkout_en,
    input  logic [CW-1:0]   settle_cycles,
    output logic [2:0]      mode,
    output logic            cpu_halt,
    output logic            clk_en,
    output logic [NMOD-1:0] mod_halt,
    output logic [NMOD-1:0] mod_rst,
    output logic            io_hold,
    output logic            io_hiz,
    output logic            clkout_high,
    output logic            clkout_hiz,
    output logic            ram_hold,
    output logic            ram_valid,
    output logic            refresh_halt,
    output logic            refresh_clr,
    output logic            refresh_rst,
    output logic            cpu_regs_lost,
    output logic            wake_irq
);
    lpm_state_e state, prev, nxt;
    lpm_ctl_t   ctl;
    logic       wake_any, wake_soft, settle_done;

    lpm_wake #(.NIRQ(NIRQ)) u_wake (
        .nmi(nmi), .irq(irq), .irq_pend(irq_pend),
        .wake_any(wake_any), .wake_soft(wake_soft)
    );

    lpm_settle #(.CW(CW)) u_settle (
        .clk(clk), .rst(rst), .active(state == M_SETTLE),
        .cycles(settle_cycles), .done(settle_done)
    );

    lpm_outmap #(.NMOD(NMOD)) u_map (
        .state(state), .mstb(mstb), .clkout_en(clkout_en),
        .ctl(ctl), .mod_halt(mod_halt), .mod_rst(mod_rst)
    );

    // Priority: standby pin, then leaving hardware standby, then reset.
    always_comb begin
        nxt = state;
        if (!stby_n)                          nxt = M_HSTBY;
        else if (state == M_HSTBY)            nxt = M_HSREC;
        else if (rst && state == M_HSREC)     nxt = M_HSREC;
        else if (rst)                         nxt = M_RESET;
        else begin
            case (state)
                M_RESET, M_HSREC: nxt = M_RUN;
                M_RUN:    if (sleep_req)   nxt = ssby_sel ? M_SSTBY : M_SLEEP;
                M_SLEEP:  if (wake_any)    nxt = M_RUN;
                M_SSTBY:  if (wake_soft)   nxt = M_SETTLE;
                M_SETTLE: if (settle_done) nxt = M_RUN;
                default:                   nxt = M_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state <= nxt;
        prev  <= state;
    end

    always_ff @(posedge clk) begin
        if (!stby_n && state != M_HSTBY)
            ram_valid <= !ram_en;
        else if (rst && state != M_HSTBY && state != M_HSREC)
            ram_valid <= 1'b0;
    end

    assign mode          = state;
    assign cpu_halt      = ctl.cpu_halt;
    assign clk_en        = ctl.clk_en;
    assign io_hold       = ctl.io_hold;
    assign io_hiz        = ctl.io_hiz;
    assign clkout_high   = ctl.clkout_high;
    assign clkout_hiz    = ctl.clkout_hiz;
    assign ram_hold      = ctl.ram_hold;
    assign refresh_halt  = ctl.refresh_halt;
    assign refresh_rst   = ctl.refresh_rst;
    assign cpu_regs_lost = ctl.regs_lost;
    assign refresh_clr   = (state == M_SSTBY) && (prev != M_SSTBY);
    assign wake_irq      = (state == M_RUN) && (prev == M_SLEEP || prev == M_SETTLE);

    // R7
    hs_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !stby_n |=> (state == M_HSTBY));
    // R8
    hs_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == M_HSTBY && stby_n) |=> (state == M_HSREC));
    // R5
    ss_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == M_SSTBY && stby_n && !nmi && irq == '0) |=> (state == M_SSTBY));
    // R4
    ss_clock_chk: assert property (@(posedge clk) disable iff (rst)
        in_soft_standby(state) |-> (!clk_en && io_hold && mod_rst == '1));
    // R11
    io_mutex_chk: assert property (@(posedge clk) disable iff (rst)
        !(io_hold && io_hiz) && !(clkout_high && clkout_hiz));
    // R3
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> !wake_irq);
    // R10
    mstb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (state == M_RUN || state == M_SLEEP) |-> (mod_halt == mstb && mod_rst == mstb));
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NMOD = 8;
    localparam int NIRQ = 3;
    localparam int CW   = 8;

    logic clk = 1'b0;
    logic rst, stby_n, sleep_req, ssby_sel, nmi, irq_pend, ram_en, clkout_en;
    logic [NIRQ-1:0] irq;
    logic [NMOD-1:0] mstb;
    logic [CW-1:0]   settle_cycles;
    logic [2:0]      mode;
    logic cpu_halt, clk_en, io_hold, io_hiz, clkout_high, clkout_hiz, ram_hold;
    logic ram_valid, refresh_halt, refresh_clr, refresh_rst, cpu_regs_lost, wake_irq;
    logic [NMOD-1:0] mod_halt, mod_rst;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpm_ctrl #(.NMOD(NMOD), .NIRQ(NIRQ), .CW(CW)) dut (
        .clk(clk), .rst(rst), .stby_n(stby_n), .sleep_req(sleep_req),
        .ssby_sel(ssby_sel), .nmi(nmi), .irq(irq), .irq_pend(irq_pend),
        .mstb(mstb), .ram_en(ram_en), .clkout_en(clkout_en),
        .settle_cycles(settle_cycles), .mode(mode), .cpu_halt(cpu_halt),
        .clk_en(clk_en), .mod_halt(mod_halt), .mod_rst(mod_rst),
        .io_hold(io_hold), .io_hiz(io_hiz), .clkout_high(clkout_high),
        .clkout_hiz(clkout_hiz), .ram_hold(ram_hold), .ram_valid(ram_valid),
        .refresh_halt(refresh_halt), .refresh_clr(refresh_clr),
        .refresh_rst(refresh_rst), .cpu_regs_lost(cpu_regs_lost),
        .wake_irq(wake_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step();
        chk("R1 mode", 32'(mode), 5);
        chk("R1 halt/clk", {cpu_halt, clk_en}, 2'b11);
        chk("R1 modules", {mod_halt, mod_rst}, 16'hFFFF);
        chk("R12 cleared", 32'(ram_valid), 0);
        rst = 1'b0;
        step();
        chk("R1 run", 32'(mode), 0);
    endtask

    task automatic t_sleep();
        mstb = 8'h5A;
        sleep_req = 1'b1; ssby_sel = 1'b0;
        step();
        sleep_req = 1'b0;
        chk("R2 mode", 32'(mode), 1);
        chk("R2 halt/clk", {cpu_halt, clk_en}, 2'b11);
        chk("R10 halt", 32'(mod_halt), 32'h5A);
        chk("R10 rst", 32'(mod_rst), 32'h5A);
        mstb = 8'h81;
        #1 chk("R10 follow", 32'(mod_rst), 32'h81);
        irq_pend = 1'b1;
        step();
        irq_pend = 1'b0;
        chk("R3 run", 32'(mode), 0);
        chk("R3 wake", 32'(wake_irq), 1);
        step();
        chk("R3 pulse end", 32'(wake_irq), 0);
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        irq = 3'b010;
        step();
        irq = '0;
        chk("R3 irq wake", {mode, wake_irq}, {3'd0, 1'b1});
    endtask

    task automatic t_soft();
        clkout_en = 1'b1; settle_cycles = 8'd3;
        sleep_req = 1'b1; ssby_sel = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R4 mode", 32'(mode), 2);
        chk("R4 ctl", {clk_en, cpu_halt, io_hold, ram_hold, refresh_halt, refresh_clr},
            6'b011111);
        chk("R4 modules", {mod_halt, mod_rst}, 16'hFFFF);
        chk("R11 high", {clkout_high, clkout_hiz}, 2'b10);
        step();
        chk("R4 clr pulse", 32'(refresh_clr), 0);
        irq_pend = 1'b1; sleep_req = 1'b1;
        step();
        irq_pend = 1'b0; sleep_req = 1'b0;
        chk("R5 ignored", 32'(mode), 2);
        irq = 3'b100;
        step();
        irq = '0;
        for (int i = 0; i < 3; i++) begin
            chk("R6 settling", {mode, clk_en, io_hold}, {3'd3, 1'b0, 1'b1});
            nmi = 1'b1;
            step();
            nmi = 1'b0;
        end
        chk("R6 run", {mode, wake_irq}, {3'd0, 1'b1});
        chk("R11 off in run", {clkout_high, clkout_hiz}, 2'b00);
        settle_cycles = 8'd0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        nmi = 1'b1;
        step();
        nmi = 1'b0;
        chk("R6 zero settle", 32'(mode), 3);
        step();
        chk("R6 zero run", {mode, wake_irq}, {3'd0, 1'b1});
        clkout_en = 1'b0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R11 unused", {mode, clkout_high}, {3'd2, 1'b0});
        nmi = 1'b1;
        step();
        nmi = 1'b0;
        step();
        chk("R6 back", 32'(mode), 0);
    endtask

    task automatic t_hard();
        clkout_en = 1'b1; ram_en = 1'b0;
        sleep_req = 1'b1; ssby_sel = 1'b0;
        step();
        sleep_req = 1'b0;
        stby_n = 1'b0; rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R7 mode", 32'(mode), 4);
        chk("R7 ctl", {io_hiz, io_hold, clk_en, cpu_regs_lost, refresh_rst}, 5'b10011);
        chk("R7 modules", {mod_halt, mod_rst}, 16'hFFFF);
        chk("R11 hiz", {clkout_high, clkout_hiz}, 2'b01);
        chk("R12 kept", 32'(ram_valid), 1);
        nmi = 1'b1; irq = 3'b111; rst = 1'b1;
        step();
        nmi = 1'b0; irq = '0; rst = 1'b0;
        chk("R8 ignores", 32'(mode), 4);
        stby_n = 1'b1;
        step();
        chk("R8 recovery", 32'(mode), 6);
        chk("R12 through recovery", 32'(ram_valid), 1);
        step();
        chk("R8 run", {mode, wake_irq}, {3'd0, 1'b0});
        ram_en = 1'b1; stby_n = 1'b0;
        step();
        chk("R12 lost", 32'(ram_valid), 0);
        stby_n = 1'b1; ram_en = 1'b0;
        step(); step();
        stby_n = 1'b0;
        step();
        stby_n = 1'b1;
        step(); step();
        chk("R12 set again", {mode, ram_valid}, {3'd0, 1'b1});
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R12 reset clears", 32'(ram_valid), 0);
        step();
    endtask

    task automatic t_prio();
        sleep_req = 1'b1; ssby_sel = 1'b0;
        step();
        sleep_req = 1'b0;
        rst = 1'b1; nmi = 1'b1;
        step();
        rst = 1'b0; nmi = 1'b0;
        chk("R9 reset wins", 32'(mode), 5);
        step();
        chk("R9 no wake", {mode, wake_irq}, {3'd0, 1'b0});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; stby_n = 1'b1; sleep_req = 1'b0; ssby_sel = 1'b0;
        nmi = 1'b0; irq = '0; irq_pend = 1'b0; mstb = '0; ram_en = 1'b0;
        clkout_en = 1'b0; settle_cycles = 8'd2;
        @(negedge clk);
        t_reset();
        t_sleep();
        t_soft();
        t_hard();
        t_prio();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule